// File: doc/BRIEF.md
# Serial Link Error Monitor with Interrupt and Resync Control

This block watches the error reports of a bank of serial links and turns them into sticky per-channel flags, an active-low interrupt and a per-channel request to restart link initialization. For every link it follows four error classes. The first is a bit-pattern fault found in an idle word. The second is a data-recovery unit that has run out of range. The third is a cell-boundary fault, where the last idle word of a cell period lacks its cell marker. The fourth is a threshold fault, raised once for every fixed number of pattern faults on the same link.

Each class has one sticky flag per channel. A flag stays set until software reads the byte that holds it, until the link reports that it has been reinitialized, or until reset. A control register selects, per class, whether a flag may pull the interrupt low and whether it requests a resync. A global resync input forces resync requests for every flagged channel, whatever the register says. Only channels whose output-enable input is high can reach the interrupt. Software reaches all registers through a byte-wide synchronous register port, and the read data appears one cycle after the read strobe.

Top module: `link_err_monitor`

## Requirements
- R1: A high `idle_pat_err[i]` sampled on a clock edge sets bit i of the link-error register. The bit then stays set until it is cleared by read, by reinit or by reset.
- R2: Each channel counts its own pattern faults. The 8th, 16th, … fault on a channel sets that channel's bit in the threshold-error register, and 7 faults leave the bit clear.
- R3: A high `recov_range_err[i]` sets bit i of the recovery-error register.
- R4: A cell error sets bit i of the cell-error register. It needs `cell_mode` high, `cell_last_idle[i]` high and `cell_last_ovh[2i+1:2i]` not equal to 2'b11. With `cell_mode` low, or with the marker 2'b11, the bit is not set.
- R5: Register addresses are: 0 status, 1 control, 2/3 cell-error bits 7:0/15:8, 4/5 recovery-error, 6/7 threshold-error, 8/9 link-error. A read with `reg_rd` high returns the byte on `reg_rdata` one cycle later and clears only that byte of an error register.
- R6: When a read-clear or a reinit hits a bit in the same cycle as a new event for that bit, the bit ends up set.
- R7: A high `link_reinit[i]` clears bit i in all four error registers and restarts channel i's fault count.
- R8: Status register bit 0 is high when any link-error bit is set. Bits 1, 2 and 3 do the same for threshold, recovery and cell errors. Bits 7:4 read 0.
- R9: The control register holds the interrupt enables for link/threshold/recovery/cell in bits 0..3 and the resync enables for the same classes in bits 4..7. A write with `reg_wr` high to address 1 loads it. Writes to any other address change no register.
- R10: `irq_n` is low exactly when some channel with `chan_oe` high has a set flag in a class whose interrupt enable is set. Once those flags clear (for example after reinit), `irq_n` returns high.
- R11: `resync_req[i]` is high while channel i has a set flag in a class whose resync enable is set. While `resync_all` is high, it is also high for any set flag on channel i.
- R12: After reset all registers read 0, `irq_n` is high and `resync_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cell_mode | input | 1 | High when the system runs in cell-synchronous mode |
| resync_all | input | 1 | Global override: request resync on every flagged channel |
| chan_oe | input | NUM_LINKS | Per-channel output enable; gates the interrupt |
| idle_pat_err | input | NUM_LINKS | Idle-word bit-pattern fault, one strobe per channel |
| recov_range_err | input | NUM_LINKS | Data-recovery out-of-range strobe per channel |
| cell_last_idle | input | NUM_LINKS | Last word of the cell period was an idle word |
| cell_last_ovh | input | 2*NUM_LINKS | Overhead bits of that idle word, two per channel |
| link_reinit | input | NUM_LINKS | Channel has just been reinitialized |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the byte read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq_n | output | 1 | Active-low interrupt |
| resync_req | output | NUM_LINKS | Per-channel resync request |

## Verification
The bench builds the block with 16 links and a threshold of 8. This gives two bytes per error register, so every byte address and the split between the LSB and MSB bytes can be checked, and a 3-bit fault counter whose wrap can be reached in eight strobes. A table of event and read pairs covers read-clear of single bytes, untouched neighbouring bytes and the same-cycle race between event and clear. Directed sequences then cover the threshold count, cell-marker gating, the control-register masks, output-enable gating of the interrupt, the global resync override and a reset in the middle of the run.

// File: rtl/lem_pkg.sv
package lem_pkg;
  localparam int NUM_CLASSES = 4;

  // Class index is also the status bit, the interrupt-enable bit and
  // (plus 4) the resync-enable bit in the control register.
  typedef enum logic [1:0] {
    CLS_LINK  = 2'd0,
    CLS_THR   = 2'd1,
    CLS_RECOV = 2'd2,
    CLS_CELL  = 2'd3
  } err_class_e;

  localparam int ADDR_STATUS  = 0;
  localparam int ADDR_CONTROL = 1;
  localparam int ADDR_FIRST_ERR = 2;
  localparam logic [1:0] CELL_MARK = 2'b11;
endpackage

// File: rtl/lem_event_decode.sv
module lem_event_decode
  import lem_pkg::*;
#(
  parameter int N      = 16,
  parameter int THRESH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cell_mode,
  input  logic [N-1:0]                 idle_pat_err,
  input  logic [N-1:0]                 recov_range_err,
  input  logic [N-1:0]                 cell_last_idle,
  input  logic [2*N-1:0]               cell_last_ovh,
  input  logic [N-1:0]                 link_reinit,
  output logic [NUM_CLASSES-1:0][N-1:0] evt
);
  localparam int CW = (THRESH > 2) ? $clog2(THRESH) : 1;
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic [N-1:0] thr_hit;
  logic [N-1:0] cell_bad;

  for (genvar i = 0; i < N; i++) begin : g_chan
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    assign thr_hit[i]  = idle_pat_err[i] && (cnt_q == LAST);
    assign cell_bad[i] = cell_mode && cell_last_idle[i] &&
                         (cell_last_ovh[2*i +: 2] != CELL_MARK);

    always_comb begin
      cnt_d = cnt_q;
      if (link_reinit[i]) begin
        cnt_d = idle_pat_err[i] ? CW'(1) : '0;
      end else if (idle_pat_err[i]) begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (idle_pat_err[i] || link_reinit[i]) begin
        cnt_q <= cnt_d;
      end
    end
  end

  always_comb begin
    evt            = '0;
    evt[CLS_LINK]  = idle_pat_err;
    evt[CLS_THR]   = thr_hit;
    evt[CLS_RECOV] = recov_range_err;
    evt[CLS_CELL]  = cell_bad;
  end
endmodule

// File: rtl/lem_sticky_bank.sv
module lem_sticky_bank
  import lem_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CLASSES-1:0][N-1:0] set_evt,
  input  logic [NUM_CLASSES-1:0][N-1:0] rd_clr,
  input  logic [N-1:0]                  chan_clr,
  output logic [NUM_CLASSES-1:0][N-1:0] flags_q
);
  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    logic [N-1:0] flags_d;
    logic         upd;

    // New events take priority over both clear sources.
    always_comb begin
      flags_d = (flags_q[c] & ~rd_clr[c] & ~chan_clr) | set_evt[c];
      upd     = |{set_evt[c], rd_clr[c], chan_clr};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[c] <= '0;
      end else if (upd) begin
        flags_q[c] <= flags_d;
      end
    end
  end
endmodule

// File: rtl/lem_regport.sv
module lem_regport
  import lem_pkg::*;
#(
  parameter int N      = 16,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [7:0]                    reg_wdata,
  input  logic [NUM_CLASSES-1:0][N-1:0] flags_q,
  output logic [7:0]                    reg_rdata,
  output logic [7:0]                    ctrl_q,
  output logic [NUM_CLASSES-1:0][N-1:0] rd_clr
);
  localparam int BYTES = N / 8;

  logic [7:0] status;
  logic [7:0] rd_val;
  logic [7:0] rdata_q;
  logic       ctrl_we;

  always_comb begin
    status = '0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      status[c] = |flags_q[c];
    end
  end

  // Error registers are laid out cell, recovery, threshold, link.
  always_comb begin
    rd_val = '0;
    rd_clr = '0;
    if (reg_addr == ADDR_W'(ADDR_STATUS)) rd_val = status;
    if (reg_addr == ADDR_W'(ADDR_CONTROL)) rd_val = ctrl_q;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      for (int b = 0; b < BYTES; b++) begin
        if (reg_addr == ADDR_W'(ADDR_FIRST_ERR + (NUM_CLASSES - 1 - c) * BYTES + b)) begin
          rd_val               = flags_q[c][b*8 +: 8];
          rd_clr[c][b*8 +: 8]  = {8{reg_rd}};
        end
      end
    end
  end

  assign ctrl_we = reg_wr && (reg_addr == ADDR_W'(ADDR_CONTROL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= rd_val;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/link_err_monitor.sv
module link_err_monitor
  import lem_pkg::*;
#(
  parameter  int NUM_LINKS = 16,
  parameter  int THRESH    = 8,
  localparam int ADDR_W    = $clog2(ADDR_FIRST_ERR + NUM_CLASSES * (NUM_LINKS / 8))
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cell_mode,
  input  logic                   resync_all,
  input  logic [NUM_LINKS-1:0]   chan_oe,
  input  logic [NUM_LINKS-1:0]   idle_pat_err,
  input  logic [NUM_LINKS-1:0]   recov_range_err,
  input  logic [NUM_LINKS-1:0]   cell_last_idle,
  input  logic [2*NUM_LINKS-1:0] cell_last_ovh,
  input  logic [NUM_LINKS-1:0]   link_reinit,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [7:0]             reg_wdata,
  output logic [7:0]             reg_rdata,
  output logic                   irq_n,
  output logic [NUM_LINKS-1:0]   resync_req
);
  logic                                  rst_meta_q;
  logic                                  rst_sync_n;
  logic [NUM_CLASSES-1:0][NUM_LINKS-1:0] evt;
  logic [NUM_CLASSES-1:0][NUM_LINKS-1:0] flags_q;
  logic [NUM_CLASSES-1:0][NUM_LINKS-1:0] rd_clr;
  logic [7:0]                            ctrl_q;
  logic [NUM_LINKS-1:0]                  irq_hit;
  logic [NUM_LINKS-1:0]                  rs_hit;

  // Reset asserts at once and is released on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  lem_event_decode #(.N(NUM_LINKS), .THRESH(THRESH)) u_decode (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .cell_mode       (cell_mode),
    .idle_pat_err    (idle_pat_err),
    .recov_range_err (recov_range_err),
    .cell_last_idle  (cell_last_idle),
    .cell_last_ovh   (cell_last_ovh),
    .link_reinit     (link_reinit),
    .evt             (evt)
  );

  lem_sticky_bank #(.N(NUM_LINKS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_evt  (evt),
    .rd_clr   (rd_clr),
    .chan_clr (link_reinit),
    .flags_q  (flags_q)
  );

  lem_regport #(.N(NUM_LINKS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .flags_q   (flags_q),
    .reg_rdata (reg_rdata),
    .ctrl_q    (ctrl_q),
    .rd_clr    (rd_clr)
  );

  always_comb begin
    irq_hit = '0;
    rs_hit  = '0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      irq_hit = irq_hit | (flags_q[c] & chan_oe & {NUM_LINKS{ctrl_q[c]}});
      rs_hit  = rs_hit  | (flags_q[c] & {NUM_LINKS{ctrl_q[4+c] | resync_all}});
    end
  end

  assign irq_n      = ~|irq_hit;
  assign resync_req = rs_hit;
endmodule

// File: rtl/link_err_monitor_chk.sv
module link_err_monitor_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cell_mode,
  input logic         resync_all,
  input logic         reg_wr,
  input logic [N-1:0] idle_pat_err,
  input logic [N-1:0] recov_range_err,
  input logic [N-1:0] link_reinit,
  input logic [N-1:0] lerr_q,
  input logic [N-1:0] derr_q,
  input logic [N-1:0] cerr_q,
  input logic [7:0]   ctrl_q,
  input logic [N-1:0] resync_req,
  input logic         irq_n
);
  AST_LINK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|idle_pat_err) |=> ((lerr_q & $past(idle_pat_err)) == $past(idle_pat_err))); // R1

  AST_RECOV_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|recov_range_err) |=> ((derr_q & $past(recov_range_err)) == $past(recov_range_err))); // R3

  AST_CELL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_mode |=> ((cerr_q & ~$past(cerr_q)) == '0)); // R4

  AST_REINIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|link_reinit) && (idle_pat_err == '0)) |=> ((lerr_q & $past(link_reinit)) == '0)); // R7

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(ctrl_q)); // R9

  AST_FORCE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    resync_all |-> ((resync_req & lerr_q) == lerr_q)); // R11

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[3:0] == 4'h0) |-> irq_n); // R10
endmodule

bind link_err_monitor link_err_monitor_chk #(.N(NUM_LINKS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .cell_mode       (cell_mode),
  .resync_all      (resync_all),
  .reg_wr          (reg_wr),
  .idle_pat_err    (idle_pat_err),
  .recov_range_err (recov_range_err),
  .link_reinit     (link_reinit),
  .lerr_q          (flags_q[0]),
  .derr_q          (flags_q[2]),
  .cerr_q          (flags_q[3]),
  .ctrl_q          (ctrl_q),
  .resync_req      (resync_req),
  .irq_n           (irq_n)
);

// File: tb/link_err_monitor_tb.sv
module link_err_monitor_tb;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cell_mode;
  logic          resync_all;
  logic [N-1:0]  chan_oe;
  logic [N-1:0]  idle_pat_err;
  logic [N-1:0]  recov_range_err;
  logic [N-1:0]  cell_last_idle;
  logic [2*N-1:0] cell_last_ovh;
  logic [N-1:0]  link_reinit;
  logic [3:0]    reg_addr;
  logic          reg_wr;
  logic          reg_rd;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic          irq_n;
  logic [N-1:0]  resync_req;

  int n_cmp  = 0;
  int n_miss = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  link_err_monitor #(.NUM_LINKS(N), .THRESH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cell_mode(cell_mode), .resync_all(resync_all),
    .chan_oe(chan_oe), .idle_pat_err(idle_pat_err), .recov_range_err(recov_range_err),
    .cell_last_idle(cell_last_idle), .cell_last_ovh(cell_last_ovh),
    .link_reinit(link_reinit), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n), .resync_req(resync_req)
  );

  typedef struct packed {
    logic [15:0] lnk;
    logic [15:0] rec;
    logic [15:0] rin;
    logic [3:0]  addr;
    logic [7:0]  exp;
  } vec_t;

  // Event pulse for one cycle, then a read of one byte (R1 R3 R5 R6).
  localparam vec_t VECS [10] = '{
    '{16'h0001, 16'h0000, 16'h0000, 4'd8, 8'h01},
    '{16'h0000, 16'h0000, 16'h0000, 4'd8, 8'h00},
    '{16'h8100, 16'h0000, 16'h0000, 4'd9, 8'h81},
    '{16'h0000, 16'h0300, 16'h0000, 4'd5, 8'h03},
    '{16'h0000, 16'h0000, 16'h0000, 4'd5, 8'h00},
    '{16'h0000, 16'h0080, 16'h0000, 4'd4, 8'h80},
    '{16'h0010, 16'h0000, 16'h0000, 4'd9, 8'h00},
    '{16'h0000, 16'h0000, 16'h0000, 4'd8, 8'h10},
    '{16'h0002, 16'h0000, 16'h0002, 4'd8, 8'h02},
    '{16'h0000, 16'h0004, 16'h0000, 4'd4, 8'h04}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    idle_pat_err    = '0;
    recov_range_err = '0;
    cell_last_idle  = '0;
    cell_last_ovh   = '0;
    link_reinit     = '0;
    reg_wr          = 1'b0;
    reg_rd          = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    reg_rd   = 1'b1;
    @(negedge clk);
    reg_rd   = 1'b0;
    d        = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] lnk, input logic [N-1:0] rec, input logic [N-1:0] rin);
    idle_pat_err    = lnk;
    recov_range_err = rec;
    link_reinit     = rin;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_miss++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    cell_mode  = 1'b0;
    resync_all = 1'b0;
    chan_oe    = '1;
    reg_addr   = '0;
    reg_wdata  = '0;
    idle_inputs();
    @(negedge clk);
    do_reset();

    // R12: reset state
    check("R12 irq_n", irq_n, 1);
    check("R12 resync_req", resync_req, 0);
    rd(4'd0, d); check("R12 status", d, 8'h00);
    rd(4'd1, d); check("R12 control", d, 8'h00);

    // Table walk
    foreach (VECS[k]) begin
      pulse(VECS[k].lnk, VECS[k].rec, VECS[k].rin);
      rd(VECS[k].addr, d);
      check($sformatf("R5 vec%0d (R1 R3 R6)", k), d, VECS[k].exp);
    end

    // R2: threshold count on a fresh channel
    do_reset();
    for (int j = 0; j < 7; j++) pulse(16'h0020, '0, '0);
    rd(4'd6, d); check("R2 seven faults", d, 8'h00);
    pulse(16'h0020, '0, '0);
    rd(4'd0, d); check("R8 status link+thr", d, 8'h03);
    rd(4'd6, d); check("R2 eighth fault", d, 8'h20);
    rd(4'd0, d); check("R8 status link only", d, 8'h01);
    rd(4'd8, d); check("R1 link sticky", d, 8'h20);
    rd(4'd0, d); check("R8 status clear", d, 8'h00);

    // R7: reinit restarts the count
    for (int j = 0; j < 5; j++) pulse(16'h0040, '0, '0);
    pulse('0, '0, 16'h0040);
    for (int j = 0; j < 7; j++) pulse(16'h0040, '0, '0);
    rd(4'd6, d); check("R7 count restarted", d, 8'h00);
    rd(4'd8, d); check("R7 link after faults", d, 8'h40);

    // R4: cell marker gating
    cell_last_idle = 16'h0008; cell_last_ovh = '0;
    @(negedge clk); idle_inputs();
    rd(4'd2, d); check("R4 cell_mode low", d, 8'h00);
    cell_mode = 1'b1;
    cell_last_idle = 16'h0008; cell_last_ovh = 32'h0000_00C0;
    @(negedge clk); idle_inputs();
    rd(4'd2, d); check("R4 marker 11", d, 8'h00);
    cell_last_idle = 16'h0008; cell_last_ovh = 32'h0000_0040;
    @(negedge clk); idle_inputs();
    rd(4'd0, d); check("R8 status cell", d, 8'h08);
    rd(4'd2, d); check("R4 marker 01", d, 8'h08);
    cell_mode = 1'b0;

    // R9: control register
    wr(4'd1, 8'h5A);
    rd(4'd1, d); check("R9 control write", d, 8'h5A);
    wr(4'd0, 8'hFF);
    wr(4'd8, 8'hFF);
    rd(4'd1, d); check("R9 other writes ignored ctrl", d, 8'h5A);
    rd(4'd8, d); check("R9 other writes ignored link", d, 8'h00);

    // R10: interrupt with output-enable gating
    wr(4'd1, 8'h01);
    chan_oe = 16'hFFFB;
    pulse(16'h0004, '0, '0);
    check("R10 oe off", irq_n, 1);
    chan_oe = 16'hFFFF;
    #1; check("R10 oe on", irq_n, 0);
    pulse('0, '0, 16'h0004);
    check("R10 after reinit", irq_n, 1);
    rd(4'd8, d); check("R7 reinit cleared", d, 8'h00);

    // R11: resync enables and override
    wr(4'd1, 8'h10);
    pulse(16'h0200, 16'h0002, '0);
    check("R11 link resync only", resync_req, 32'h0200);
    wr(4'd1, 8'h00);
    check("R11 disabled", resync_req, 0);
    resync_all = 1'b1;
    #1; check("R11 override", resync_req, 32'h0202);
    resync_all = 1'b0;
    pulse('0, '0, 16'h0202);
    check("R11 after reinit", resync_req, 0);

    // R12: reset in mid-run
    wr(4'd1, 8'hFF);
    pulse(16'h0101, 16'h0101, '0);
    check("R12 pre-reset irq", irq_n, 0);
    do_reset();
    check("R12 irq after reset", irq_n, 1);
    check("R12 resync after reset", resync_req, 0);
    rd(4'd8, d); check("R12 link after reset", d, 8'h00);
    rd(4'd1, d); check("R12 ctrl after reset", d, 8'h00);

    finish_run();
  end
endmodule